// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps program order for a pipeline whose functional units finish in any order. The decode stage asks for a slot. When the queue grants it, the slot index comes back as a tag that travels with the operation. When a functional unit finishes, it uses the tag to write its result, any store address and data, and an exception flag into that slot. Nothing reaches architectural state at completion time.

Each cycle the queue looks only at its oldest slot. A finished slot with no fault is released in that cycle: a register write goes to a write port, or a store goes to a memory write port, and the slot is freed. A finished slot that carries a fault releases nothing. In that cycle the queue raises a redirect, shows the faulting PC and a fixed handler vector, and drops every younger slot. Architectural state therefore always matches a sequential machine that stops just before the faulting operation.

The queue has eight slots by default and handles at most one grant, one completion and one release per cycle.

Top module: `retire_queue`

## Requirements
- R1: After reset the granted tag `allocTag` is 0. Each accepted request (`allocValid` and `allocReady` both high at a clock edge) advances it by one, wrapping from DEPTH-1 to 0, so tags follow program order.
- R2: With DEPTH slots occupied, `full` is high and `allocReady` is low. A request made while `allocReady` is low is ignored and leaves `allocTag` unchanged.
- R3: After reset `empty` is high and `full` is low. While the queue is empty, `regWe`, `memWe` and `redirect` stay low.
- R4: A completion into a younger slot produces no register or memory write while an older slot is still unfinished.
- R5: Once the oldest slot is finished without a fault, it is released in the following cycle. A register slot drives `regWe` high together with its `regId` and `regValue`. Slots are released one per cycle, in tag order.
- R6: A register slot whose destination ID is 0 is released without raising `regWe`, and the next slot follows in the next cycle.
- R7: A store slot (`allocIsStore` = 1) is released as a single-cycle `memWe` with `memAddr` and `memData` from its completion, and `regWe` stays low.
- R8: When the oldest slot is finished with `cmplExc` = 1, `redirect` is high for one cycle. In that cycle `faultPc` equals the slot's PC, `redirectPc` equals HANDLER_PC and nothing is written. On the next cycle the queue is empty, no younger slot is ever released, and `allocTag` is the faulting tag plus one.
- R9: A fault recorded in a younger slot raises no redirect while older slots remain. Older finished slots are released first.
- R10: In the redirect cycle `allocReady` is low, and a request made then is not accepted.
- R11: An accepted request and a release in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Decode requests a slot |
| allocPc | input | PC_W | PC of the operation being queued |
| allocDestReg | input | REG_W | Destination register ID |
| allocIsStore | input | 1 | Operation is a store |
| allocReady | output | 1 | A request is accepted this cycle |
| allocTag | output | PTR_W | Slot index granted to the request |
| cmplValid | input | 1 | A functional unit finished |
| cmplTag | input | PTR_W | Slot the finished result belongs to |
| cmplValue | input | DATA_W | Register result |
| cmplStAddr | input | ADDR_W | Store address |
| cmplStData | input | DATA_W | Store data |
| cmplExc | input | 1 | The operation faulted |
| regWe | output | 1 | Register write strobe |
| regId | output | REG_W | Register written |
| regValue | output | DATA_W | Value written |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Store address |
| memData | output | DATA_W | Store data |
| redirect | output | 1 | Flush and redirect fetch to the handler |
| redirectPc | output | PC_W | Handler vector |
| faultPc | output | PC_W | PC of the faulting operation |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The hardest state to reach is a fault that sits behind an older unfinished slot while the queue is full and its pointers have wrapped. Younger slots have to be finished before the fault reaches the head, so that the flush is seen to discard results that would otherwise be released. The stimulus first drains several slots so that the head lies mid-ring, then fills all slots across the wrap point and trades one release against one request. It then completes, in this order, a younger faulting slot, a slot behind that fault, and finally the oldest slot. While the redirect is up, the stimulus also tries to allocate.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic alloc;   // write a new slot at the tail
    logic cmplWr;  // record a completion at cmplTag
    logic retire;  // release head slot
    logic flush;   // head faulted: drop everything
  } rqStrobe_t;
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             cmplValid,
  input  logic             headValid,
  input  logic             headDone,
  input  logic             headExc,
  output rqStrobe_t        st,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic             allocReady,
  output logic             full,
  output logic             empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             flushNow;
  logic             retireNow;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    empty      = (count == '0);
    full       = (count == CNT_W'(DEPTH));
    flushNow   = headValid && headDone && headExc;
    retireNow  = headValid && headDone && !headExc;
    allocReady = !full && !flushNow;
    st.alloc   = allocValid && allocReady;
    st.cmplWr  = cmplValid && !flushNow;
    st.retire  = retireNow;
    st.flush   = flushNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (st.flush) begin
      headPtr <= nextPtr(headPtr);
      tailPtr <= nextPtr(headPtr);
      count   <= '0;
    end else begin
      if (st.retire) headPtr <= nextPtr(headPtr);
      if (st.alloc)  tailPtr <= nextPtr(tailPtr);
      count <= count + CNT_W'(st.alloc) - CNT_W'(st.retire);
    end
  end
endmodule

// File: rtl/rq_data.sv
module rq_data
  import rq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rqStrobe_t         st,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [PC_W-1:0]   allocPc,
  input  logic [REG_W-1:0]  allocDestReg,
  input  logic              allocIsStore,
  input  logic [PTR_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic [ADDR_W-1:0] cmplStAddr,
  input  logic [DATA_W-1:0] cmplStData,
  input  logic              cmplExc,
  output logic              headValid,
  output logic              headDone,
  output logic              headExc,
  output logic [PC_W-1:0]   headPc,
  output logic              regWe,
  output logic [REG_W-1:0]  regId,
  output logic [DATA_W-1:0] regValue,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  logic [DEPTH-1:0]  slotValid;
  logic [DEPTH-1:0]  slotDone;
  logic [DEPTH-1:0]  slotExc;
  logic [DEPTH-1:0]  slotStore;
  logic [REG_W-1:0]  slotDest  [DEPTH];
  logic [PC_W-1:0]   slotPc    [DEPTH];
  logic [DATA_W-1:0] slotValue [DEPTH];
  logic [ADDR_W-1:0] slotAddr  [DEPTH];
  logic [DATA_W-1:0] slotData  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hitAlloc;
    logic hitCmpl;
    logic hitRetire;
    assign hitAlloc  = st.alloc && (tailPtr == PTR_W'(i));
    assign hitCmpl   = st.cmplWr && (cmplTag == PTR_W'(i)) && slotValid[i];
    assign hitRetire = st.retire && (headPtr == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        slotDone[i]  <= 1'b0;
        slotExc[i]   <= 1'b0;
      end else if (st.flush) begin
        slotValid[i] <= 1'b0;
        slotDone[i]  <= 1'b0;
      end else if (hitAlloc) begin
        slotValid[i] <= 1'b1;
        slotDone[i]  <= 1'b0;
        slotExc[i]   <= 1'b0;
      end else if (hitRetire) begin
        slotValid[i] <= 1'b0;
        slotDone[i]  <= 1'b0;
      end else if (hitCmpl) begin
        slotDone[i]  <= 1'b1;
        slotExc[i]   <= cmplExc;
      end
    end

    always_ff @(posedge clk) begin
      if (hitAlloc) begin
        slotPc[i]    <= allocPc;
        slotDest[i]  <= allocDestReg;
        slotStore[i] <= allocIsStore;
      end
      if (hitCmpl) begin
        slotValue[i] <= cmplValue;
        slotAddr[i]  <= cmplStAddr;
        slotData[i]  <= cmplStData;
      end
    end
  end

  always_comb begin
    headValid = slotValid[headPtr];
    headDone  = slotDone[headPtr];
    headExc   = slotExc[headPtr];
    headPc    = slotPc[headPtr];
    regWe     = st.retire && !slotStore[headPtr] && (slotDest[headPtr] != '0);
    regId     = slotDest[headPtr];
    regValue  = slotValue[headPtr];
    memWe     = st.retire && slotStore[headPtr];
    memAddr   = slotAddr[headPtr];
    memData   = slotData[headPtr];
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int              DEPTH      = 8,
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 32,
  parameter int              PC_W       = 32,
  parameter int              REG_W      = 5,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080,
  localparam int             PTR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [PC_W-1:0]   allocPc,
  input  logic [REG_W-1:0]  allocDestReg,
  input  logic              allocIsStore,
  output logic              allocReady,
  output logic [PTR_W-1:0]  allocTag,
  input  logic              cmplValid,
  input  logic [PTR_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic [ADDR_W-1:0] cmplStAddr,
  input  logic [DATA_W-1:0] cmplStData,
  input  logic              cmplExc,
  output logic              regWe,
  output logic [REG_W-1:0]  regId,
  output logic [DATA_W-1:0] regValue,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              redirect,
  output logic [PC_W-1:0]   redirectPc,
  output logic [PC_W-1:0]   faultPc,
  output logic              full,
  output logic              empty
);
  rqStrobe_t        st;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic             headValid;
  logic             headDone;
  logic             headExc;
  logic [PC_W-1:0]  headPc;

  rq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .cmplValid  (cmplValid),
    .headValid  (headValid),
    .headDone   (headDone),
    .headExc    (headExc),
    .st         (st),
    .headPtr    (headPtr),
    .tailPtr    (tailPtr),
    .allocReady (allocReady),
    .full       (full),
    .empty      (empty)
  );

  rq_data #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .PC_W(PC_W), .REG_W(REG_W)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .headPtr      (headPtr),
    .tailPtr      (tailPtr),
    .allocPc      (allocPc),
    .allocDestReg (allocDestReg),
    .allocIsStore (allocIsStore),
    .cmplTag      (cmplTag),
    .cmplValue    (cmplValue),
    .cmplStAddr   (cmplStAddr),
    .cmplStData   (cmplStData),
    .cmplExc      (cmplExc),
    .headValid    (headValid),
    .headDone     (headDone),
    .headExc      (headExc),
    .headPc       (headPc),
    .regWe        (regWe),
    .regId        (regId),
    .regValue     (regValue),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memData      (memData)
  );

  assign allocTag   = tailPtr;
  assign redirect   = st.flush;
  assign faultPc    = headPc;
  assign redirectPc = HANDLER_PC;
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [PTR_W-1:0] allocTag,
  input logic             regWe,
  input logic [REG_W-1:0] regId,
  input logic             memWe,
  input logic             redirect,
  input logic             full,
  input logic             empty
);
  // R1: accepted request advances the tag with wrap
  p_tag_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady) |=>
      (allocTag == (($past(allocTag) == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'($past(allocTag) + 1'b1))));

  // R2: no grant while full
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !allocReady);

  // R2: without an accepted request or flush, the tag holds
  p_tag_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(allocValid && allocReady) && !redirect) |=> $stable(allocTag));

  // R3: an empty queue writes nothing
  p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !(regWe || memWe || redirect));

  // R3: full and empty exclusive
  p_full_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R6: register zero never written
  p_reg_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regId != '0));

  // R7: store release excludes register write
  p_store_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !regWe);

  // R8: redirect writes nothing and leaves the queue empty
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> !(regWe || memWe));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> empty);

  // R10: no grant in the redirect cycle
  p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> !allocReady);
endmodule

bind retire_queue rq_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .allocValid (allocValid),
  .allocReady (allocReady),
  .allocTag   (allocTag),
  .regWe      (regWe),
  .regId      (regId),
  .memWe      (memWe),
  .redirect   (redirect),
  .full       (full),
  .empty      (empty)
);

// File: tb/sim_retire_queue.sv
`timescale 1ns/100ps
module sim_retire_queue;
  localparam int DEPTH = 8;
  localparam int PTR_W = 3;
  localparam logic [31:0] HANDLER = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic [31:0] allocPc = '0;
  logic [4:0]  allocDestReg = '0;
  logic        allocIsStore = 1'b0;
  logic        allocReady;
  logic [PTR_W-1:0] allocTag;
  logic        cmplValid = 1'b0;
  logic [PTR_W-1:0] cmplTag = '0;
  logic [31:0] cmplValue = '0;
  logic [31:0] cmplStAddr = '0;
  logic [31:0] cmplStData = '0;
  logic        cmplExc = 1'b0;
  logic        regWe;
  logic [4:0]  regId;
  logic [31:0] regValue;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        redirect;
  logic [31:0] redirectPc;
  logic [31:0] faultPc;
  logic        full;
  logic        empty;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  retire_queue u0 (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocPc(allocPc), .allocDestReg(allocDestReg),
    .allocIsStore(allocIsStore), .allocReady(allocReady), .allocTag(allocTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplValue(cmplValue),
    .cmplStAddr(cmplStAddr), .cmplStData(cmplStData), .cmplExc(cmplExc),
    .regWe(regWe), .regId(regId), .regValue(regValue),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .redirect(redirect), .redirectPc(redirectPc), .faultPc(faultPc),
    .full(full), .empty(empty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    #1;
  endtask

  task automatic allocOne(input logic [31:0] pc, input logic [4:0] rd, input logic isSt,
                          input int expTag, input string req);
    allocValid = 1'b1; allocPc = pc; allocDestReg = rd; allocIsStore = isSt;
    #0.2;
    chk(req, "allocReady", allocReady, 1);
    chk(req, "allocTag", allocTag, expTag);
    cyc();
    allocValid = 1'b0;
    #0.2;
  endtask

  task automatic cmplOne(input int tag, input logic [31:0] val, input logic [31:0] addr,
                         input logic [31:0] data, input logic exc);
    cmplValid = 1'b1; cmplTag = PTR_W'(tag); cmplValue = val;
    cmplStAddr = addr; cmplStData = data; cmplExc = exc;
    cyc();
    cmplValid = 1'b0; cmplExc = 1'b0;
    #0.2;
  endtask

  task automatic testReset;
    chk("R3", "empty", empty, 1);
    chk("R3", "full", full, 0);
    chk("R3", "regWe", regWe, 0);
    chk("R3", "redirect", redirect, 0);
    chk("R1", "allocTag", allocTag, 0);
  endtask

  task automatic testOutOfOrder;
    allocOne(32'h100, 5'd1, 1'b0, 0, "R1");
    allocOne(32'h104, 5'd2, 1'b0, 1, "R1");
    allocOne(32'h108, 5'd3, 1'b0, 2, "R1");
    cmplOne(2, 32'hA002, '0, '0, 1'b0);
    chk("R4", "regWe after young cmpl", regWe, 0);
    cmplOne(1, 32'hA001, '0, '0, 1'b0);
    chk("R4", "regWe after mid cmpl", regWe, 0);
    cmplOne(0, 32'hA000, '0, '0, 1'b0);
    chk("R5", "regWe 0", regWe, 1);
    chk("R5", "regId 0", regId, 1);
    chk("R5", "regValue 0", regValue, 32'hA000);
    cyc();
    chk("R5", "regId 1", regId, 2);
    chk("R5", "regValue 1", regValue, 32'hA001);
    cyc();
    chk("R5", "regId 2", regId, 3);
    chk("R5", "regValue 2", regValue, 32'hA002);
    cyc();
    chk("R5", "empty after drain", empty, 1);
    chk("R5", "regWe after drain", regWe, 0);
  endtask

  task automatic testZeroDest;
    allocOne(32'h10C, 5'd0, 1'b0, 3, "R6");
    allocOne(32'h110, 5'd4, 1'b0, 4, "R6");
    cmplOne(4, 32'hB004, '0, '0, 1'b0);
    cmplOne(3, 32'hB003, '0, '0, 1'b0);
    chk("R6", "regWe for reg zero", regWe, 0);
    chk("R6", "memWe for reg zero", memWe, 0);
    chk("R6", "not empty", empty, 0);
    cyc();
    chk("R6", "next regWe", regWe, 1);
    chk("R6", "next regId", regId, 4);
    cyc();
    chk("R6", "empty", empty, 1);
  endtask

  task automatic testStore;
    allocOne(32'h140, 5'd7, 1'b1, 5, "R7");
    cmplOne(5, '0, 32'h5000, 32'hBEEF, 1'b0);
    chk("R7", "memWe", memWe, 1);
    chk("R7", "memAddr", memAddr, 32'h5000);
    chk("R7", "memData", memData, 32'hBEEF);
    chk("R7", "regWe on store", regWe, 0);
    cyc();
    chk("R7", "memWe pulse ends", memWe, 0);
    chk("R7", "empty", empty, 1);
  endtask

  task automatic testFullWrap;
    for (int i = 0; i < DEPTH; i++)
      allocOne(32'h200 + 32'(4 * i), 5'(i + 1), 1'b0, (6 + i) % DEPTH, "R1");
    chk("R2", "full", full, 1);
    chk("R2", "allocReady", allocReady, 0);
    allocValid = 1'b1; allocPc = 32'hDEAD; allocDestReg = 5'd30;
    #0.2;
    chk("R2", "ready while full", allocReady, 0);
    cyc();
    allocValid = 1'b0;
    #0.2;
    chk("R2", "tag after refused", allocTag, 6);
    cmplOne(6, 32'hC006, '0, '0, 1'b0);
    chk("R5", "retire tag6", regId, 1);
    cyc();
    chk("R2", "not full after release", full, 0);
    chk("R2", "tag still 6", allocTag, 6);
    cmplOne(7, 32'hC007, '0, '0, 1'b0);
    chk("R11", "release in cycle", regWe, 1);
    allocOne(32'h300, 5'd9, 1'b0, 6, "R11");
    chk("R11", "occupancy unchanged", full, 0);
    chk("R11", "tag", allocTag, 7);
    allocOne(32'h304, 5'd10, 1'b0, 7, "R11");
    chk("R11", "full after one more", full, 1);
  endtask

  task automatic testFault;
    cmplOne(1, 32'hD001, '0, '0, 1'b1);
    chk("R9", "no redirect behind older", redirect, 0);
    cmplOne(2, 32'hD002, '0, '0, 1'b0);
    chk("R9", "no redirect yet", redirect, 0);
    cmplOne(0, 32'hD000, '0, '0, 1'b0);
    chk("R9", "older released first", regWe, 1);
    chk("R9", "older regId", regId, 3);
    chk("R9", "redirect held", redirect, 0);
    cyc();
    chk("R8", "redirect", redirect, 1);
    chk("R8", "faultPc", faultPc, 32'h20C);
    chk("R8", "redirectPc", redirectPc, HANDLER);
    chk("R8", "no regWe", regWe, 0);
    allocValid = 1'b1; allocPc = 32'h400; allocDestReg = 5'd11;
    #0.2;
    chk("R10", "ready in flush", allocReady, 0);
    cyc();
    allocValid = 1'b0;
    #0.2;
    chk("R8", "redirect one cycle", redirect, 0);
    chk("R8", "empty after flush", empty, 1);
    chk("R8", "tag after flush", allocTag, 2);
    chk("R10", "request not taken", empty, 1);
    chk("R8", "younger not released", regWe, 0);
    cyc();
    chk("R8", "still quiet", regWe, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testOutOfOrder();
    testZeroDest();
    testStore();
    testFullWrap();
    testFault();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule